// File: doc/BRIEF.md
# Pseudo-SRAM Page-Burst Read Engine

This engine fetches a short run of consecutive 16-bit words from an asynchronous pseudo-SRAM. It uses the memory's in-page fast access. A client asks for a start word address and a length of 1 to 16 words. The engine lowers chip enable and output enable and presents the full address. It waits the long random-access latency for the first word. It then moves only the four low address bits, one step per word. Each in-page step waits only the short page latency. Every word is captured on the clock edge that closes its timing window. The word then appears for one cycle on a streaming output, with a flag on the final word of the request.

All timing is counted in clock cycles. With a 4 ns clock, the defaults are 18 cycles for a random access (at least 70 ns), 5 cycles for a page step (at least 20 ns) and 3 cycles of enable-high recovery (at least 10 ns). A request that runs past the end of a 16-word page continues at the next page with a new full-latency access, and chip enable stays low. The engine also tracks how long chip enable has been low. If the next access would push that time past a configured ceiling (10 µs by default), it raises chip enable for the recovery time and restarts with a full-latency access.

Top module: `prb_burst_reader`

## Requirements
- R1: While `rst_n` is low and after it is released, `req_ready` is 1, `mem_ce_n` and `mem_oe_n` are 1, and `out_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The length of the request is `req_len_m1`+1 words, where `req_len_m1` is a 4-bit field. The words for addresses `req_addr`, `req_addr`+1, and so on are delivered in that order. `out_last` is 1 only together with the final word.
- R3: In the cycle after a request is taken, `mem_ce_n` and `mem_oe_n` are 0 and `mem_addr` equals `req_addr`. The first word is on the output FIRST_CYC clock edges after the taking edge.
- R4: When the next word lies in the same 16-word page, only `mem_addr` bits [3:0] change, and they increase by 1. That word appears PAGE_CYC edges after the previous word.
- R5: When the previous word sat at page offset 15, the address moves to offset 0 of the following page, with the upper bits incremented and wrapping at the top of the address space. Chip enable stays low, and the word appears FIRST_CYC edges after the previous word.
- R6: Count the cycles of all accesses made since chip enable last fell, and add the cycles of the next access. If that sum would exceed MAX_ACT_CYC, chip enable and output enable go high for CEH_CYC cycles. The engine then restarts with a full access, and that word appears CEH_CYC+FIRST_CYC edges after the previous word. Chip enable is never low for more than MAX_ACT_CYC consecutive cycles.
- R7: `req_ready` is 0 whenever chip enable is low. After the final word, chip enable stays high for exactly CEH_CYC cycles before `req_ready` returns to 1.
- R8: Each word is the value on `mem_dq` at the clock edge that closes its access window. `out_valid` is high for one cycle per word.
- R9: `req_valid` asserted while `req_ready` is 0 has no effect: the running request delivers its own words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request can be taken |
| req_addr | input | ADDR_W | Word address of the first word |
| req_len_m1 | input | PAGE_BITS | Number of words minus one |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | input | DATA_W | Memory read data |
| out_valid | output | 1 | Output word valid this cycle |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of the request |

## Verification
The bound checker verifies four properties on every cycle:
- Within one enable-low stretch, every address change is a +1 step that coincides with a delivered word.
- The upper address bits change only after offset 15.
- Ready stays low while the memory is enabled, and valid pulses last a single cycle.
- A counter confirms that enable-low time never exceeds the ceiling.

Some behaviour can only be shown by the bench's scenarios. The bench uses a memory model that drives good data only after the real nanosecond latencies have elapsed. Its scenarios show the exact cycle of each word, the data order across page and address-space wraps, the splitting of a long burst once the ceiling is reached, the recovery gap at the end of a request, and that a request raised while the engine is busy is ignored.

// File: rtl/prb_pkg.sv
package prb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } prb_state_e;
endpackage

// File: rtl/prb_timer.sv
// Down-counter that marks the last cycle of an access or recovery window.
module prb_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/prb_budget.sv
// Tracks enable-low cycles and flags when the next access would overrun the ceiling.
module prb_budget #(
    parameter int MAX_ACT_CYC = 2500,
    parameter int NEED_W      = 6,
    localparam int BW         = $clog2(MAX_ACT_CYC + (1 << NEED_W) + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [NEED_W-1:0] need,
    output logic              over
);
    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (ce_n)
            cnt_d = '0;
        else if (cnt_q != {BW{1'b1}})
            cnt_d = cnt_q + BW'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // cycles already spent = cnt_q + 1 at the closing edge of an access
    assign over = (cnt_q + BW'(need) + BW'(1)) > BW'(MAX_ACT_CYC);
endmodule

// File: rtl/prb_step.sv
// Next word address and end-of-page detection.
module prb_step #(
    parameter int ADDR_W    = 21,
    parameter int PAGE_BITS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_next,
    output logic              page_end
);
    assign addr_next = addr + ADDR_W'(1);
    assign page_end  = &addr[PAGE_BITS-1:0];
endmodule

// File: rtl/prb_burst_reader.sv
module prb_burst_reader
    import prb_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 16,
    parameter int PAGE_BITS   = 4,
    parameter int FIRST_CYC   = 18,
    parameter int PAGE_CYC    = 5,
    parameter int CEH_CYC     = 3,
    parameter int MAX_ACT_CYC = 2500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [PAGE_BITS-1:0] req_len_m1,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    input  logic [DATA_W-1:0]    mem_dq,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_last
);
    localparam int LEN_W = PAGE_BITS + 1;
    localparam int TMR_W = $clog2(FIRST_CYC + PAGE_CYC + CEH_CYC + 1);

    typedef struct packed {
        prb_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              ce_n;
        logic              resume;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              last;
    } regs_t;

    regs_t r_d, r_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [TMR_W-1:0]  need;
    logic              over;
    logic [ADDR_W-1:0] addr_next;
    logic              page_end;

    prb_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    prb_budget #(.MAX_ACT_CYC(MAX_ACT_CYC), .NEED_W(TMR_W)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (r_q.ce_n),
        .need  (need),
        .over  (over)
    );

    prb_step #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step (
        .addr      (r_q.addr),
        .addr_next (addr_next),
        .page_end  (page_end)
    );

    // next access after the current word: full latency at a page crossing
    assign need = page_end ? TMR_W'(FIRST_CYC) : TMR_W'(PAGE_CYC);

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.last = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_ACCESS;
                    r_d.addr = req_addr;
                    r_d.left = LEN_W'(req_len_m1) + LEN_W'(1);
                    r_d.ce_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(FIRST_CYC - 1);
                end
            end
            ST_ACCESS: begin
                if (tmr_done) begin
                    r_d.vld  = 1'b1;
                    r_d.data = mem_dq;
                    r_d.left = r_q.left - LEN_W'(1);
                    tmr_load = 1'b1;
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.last   = 1'b1;
                        r_d.st     = ST_GAP;
                        r_d.resume = 1'b0;
                        r_d.ce_n   = 1'b1;
                        tmr_val    = TMR_W'(CEH_CYC - 1);
                    end else begin
                        r_d.addr = addr_next;
                        if (over) begin
                            r_d.st     = ST_GAP;
                            r_d.resume = 1'b1;
                            r_d.ce_n   = 1'b1;
                            tmr_val    = TMR_W'(CEH_CYC - 1);
                        end else begin
                            tmr_val = need - TMR_W'(1);
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    if (r_q.resume) begin
                        r_d.st   = ST_ACCESS;
                        r_d.ce_n = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(FIRST_CYC - 1);
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.addr   <= '0;
            r_q.left   <= '0;
            r_q.ce_n   <= 1'b1;
            r_q.resume <= 1'b0;
            r_q.vld    <= 1'b0;
            r_q.data   <= '0;
            r_q.last   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.ce_n;
    assign out_valid = r_q.vld;
    assign out_data  = r_q.data;
    assign out_last  = r_q.last;
endmodule

// File: rtl/prb_burst_reader_chk.sv
module prb_burst_reader_chk #(
    parameter int ADDR_W      = 21,
    parameter int PAGE_BITS   = 4,
    parameter int MAX_ACT_CYC = 2500,
    localparam int CW         = $clog2(MAX_ACT_CYC + 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              out_valid,
    input logic              out_last
);
    logic [ADDR_W-1:0] addr_prev_q;
    logic [ADDR_W-1:0] addr_inc;
    logic              ce_prev_q;
    logic [CW-1:0]     low_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_prev_q <= '0;
            ce_prev_q   <= 1'b1;
            low_cnt_q   <= '0;
        end else begin
            addr_prev_q <= mem_addr;
            ce_prev_q   <= mem_ce_n;
            if (mem_ce_n)
                low_cnt_q <= '0;
            else if (low_cnt_q != {CW{1'b1}})
                low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    assign addr_inc = addr_prev_q + ADDR_W'(1);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !ce_prev_q && mem_addr != addr_prev_q)
            |-> (mem_addr == addr_inc && out_valid));

    a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !ce_prev_q &&
         mem_addr[ADDR_W-1:PAGE_BITS] != addr_prev_q[ADDR_W-1:PAGE_BITS])
            |-> (&addr_prev_q[PAGE_BITS-1:0]));

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r8_one_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r2_last_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r6_active_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= CW'(MAX_ACT_CYC));
endmodule

bind prb_burst_reader prb_burst_reader_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS),
    .MAX_ACT_CYC (MAX_ACT_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/prb_burst_reader_tb_top.sv
module prb_burst_reader_tb_top;
    localparam int CLK_NS   = 4;
    localparam int ACC_NS   = 70;
    localparam int PAGE_NS  = 20;
    localparam int F        = 18;
    localparam int P        = 5;
    localparam int CEH      = 3;
    localparam int MAX      = 40;
    localparam int NVEC     = 7;

    // {poke, start address, length-1}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 21'h000000, 4'd0},
        {1'b0, 21'h012345, 4'd3},
        {1'b1, 21'h01ABCD, 4'd5},
        {1'b0, 21'h0000F0, 4'd15},
        {1'b0, 21'h1FFFFF, 4'd2},
        {1'b1, 21'h00A0A7, 4'd8},
        {1'b0, 21'h15555C, 4'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic [3:0]  req_len_m1 = '0;
    logic [20:0] mem_addr;
    logic        mem_ce_n, mem_oe_n;
    logic [15:0] mem_dq = '0;
    logic        out_valid, out_last;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    prb_burst_reader #(
        .FIRST_CYC(F), .PAGE_CYC(P), .CEH_CYC(CEH), .MAX_ACT_CYC(MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [15:0] pat(input logic [20:0] a);
        return a[15:0] ^ {a[20:16], 11'h2A5};
    endfunction

    // memory model: good data only once the nanosecond latencies have elapsed
    int          full_age = 0;
    int          page_age = 0;
    logic [20:0] prev_addr = '0;
    logic        prev_ce_n = 1'b1;
    always @(negedge clk) begin
        if (mem_ce_n || prev_ce_n || mem_addr[20:4] != prev_addr[20:4]) full_age = 0;
        else full_age = full_age + 1;
        if (full_age == 0 || mem_addr != prev_addr) page_age = 0;
        else page_age = page_age + 1;
        prev_addr = mem_addr;
        prev_ce_n = mem_ce_n;
        if (!mem_ce_n && !mem_oe_n && (full_age + 1) * CLK_NS >= ACC_NS &&
            (page_age + 1) * CLK_NS >= PAGE_NS)
            mem_dq = pat(mem_addr);
        else
            mem_dq = 16'hBAD0 ^ mem_addr[15:0];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [20:0] a, input logic [3:0] lm1, input bit poke);
        int n;
        int k;
        int got;
        int t_exp;
        int act;
        int need;
        int gap;
        logic [20:0] wa;
        string tag;
        n = int'(lm1) + 1;
        k = 0; got = 0; t_exp = 0; act = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len_m1 = lm1;
        @(posedge clk);
        @(negedge clk);
        req_valid = poke; req_addr = ~a; req_len_m1 = 4'hF;
        check(!mem_ce_n && !mem_oe_n && mem_addr == a, "R3", {mem_ce_n, mem_addr}, {1'b0, a});
        while (got < n && k < 3000) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (out_valid) begin
                wa = a + 21'(got);
                if (got == 0) begin
                    t_exp = F; act = F; tag = "R3";
                end else begin
                    need = (wa[3:0] == 4'd0) ? F : P;
                    tag  = (need == F) ? "R5" : "R4";
                    if (act + need > MAX) begin
                        t_exp += CEH + F; act = F; tag = "R6";
                    end else begin
                        t_exp += need; act += need;
                    end
                end
                check(k == t_exp, tag, k, t_exp);
                check(out_data == pat(wa), poke ? "R9" : "R8", out_data, pat(wa));
                check(out_last == (got == n - 1), "R2", out_last, (got == n - 1));
                got++;
                if (got == n) req_valid = 1'b0;
            end
        end
        check(got == n, "R2", got, n);
        gap = 0;
        while (!req_ready && gap < 100) begin
            check(mem_ce_n && mem_oe_n, "R7", mem_ce_n, 1);
            gap++;
            @(negedge clk);
        end
        check(gap == CEH, "R7", gap, CEH);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state while held
        check(req_ready == 1'b1, "R1", req_ready, 1);
        check(mem_ce_n && mem_oe_n, "R1", {mem_ce_n, mem_oe_n}, 2'b11);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready && mem_ce_n && !out_valid, "R1",
              {req_ready, mem_ce_n, out_valid}, 3'b110);

        for (int v = 0; v < NVEC; v++)
            run_burst(VEC[v][24:4], VEC[v][3:0], VEC[v][25]);

        // R9: idle after a poked burst; nothing started on its own
        repeat (5) @(negedge clk);
        check(mem_ce_n && req_ready && !out_valid, "R9",
              {mem_ce_n, req_ready, out_valid}, 3'b110);

        // R1: reset in the middle of a burst returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 21'h000400; req_len_m1 = 4'd7;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_oe_n && !out_valid, "R1",
              {req_ready, mem_ce_n, mem_oe_n, out_valid}, 4'b1110);
        rst_n = 1'b1;
        run_burst(21'h00004E, 4'd4, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule